// File: doc/BRIEF.md
# Four-Shape Table Waveform Source

This block generates a periodic stream of digital samples for an external digital-to-analog converter. An internal phase counter advances by one on every clock in which the step enable is high, and a two-bit shape select picks one of four waveforms: sine, square, triangle or sawtooth. Each sample is an unsigned offset-binary code. The lowest code is the most negative level, the all-ones code is the most positive level, and the half-scale code is the zero crossing.

The phase counter and the shape select together form the lookup address. Each period holds 2^RES_W samples, which is 256 at the default width, so the waveform frequency is the step rate divided by that count. Every sample is computed in logic or in tables built at elaboration time, and no memory image is loaded. The sine uses a quarter-wave magnitude table and reflects it to cover the full period. The other three shapes come straight from phase arithmetic. The output sample is registered, and a one-cycle valid strobe marks each cycle in which a new sample was issued.

Top module: `wavegen_top`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, the phase clears to 0, `sample_vld` goes low, and `sample` takes the phase-0 value of the shape selected in that cycle (sine 0x80, square 0xFF, triangle 0x80, sawtooth 0x00 at RES_W=8).
- R2: On each edge with `step_en` high and `rst` low, `sample` takes the value of the selected shape at the current phase, `sample_vld` is high in the following cycle, and the phase advances by one. The phase wraps from 0xFF to 0x00, so each period spans exactly 256 samples.
- R3: On an edge with `step_en` low and `rst` low, the phase and `sample` keep their values and `sample_vld` is low, even if `shape_sel` changes.
- R4: `shape_sel` encodes 0 as sine, 1 as square, 2 as triangle and 3 as sawtooth. A new select value applies to the very next issued sample and never resets or disturbs the phase.
- R5: Sine at phase p: for p below 0x80 the sample is 0x80 + round(127·sin(2πp/256)); for p of 0x80 and above it is 0x7F − round(127·sin(2π(p−0x80)/256)). This gives 0xFF at p=0x40, 0x7F at p=0x80 and 0x00 at p=0xC0.
- R6: Square at phase p is 0xFF for p in 0x00..0x7F and 0x00 for p in 0x80..0xFF.
- R7: Triangle at phase p is 0x80+2p for p<0x40, 0xFE−2(p−0x40) for 0x40≤p<0x80, 0x7E−2(p−0x80) for 0x80≤p<0xC0, and 0x02+2(p−0xC0) for p≥0xC0.
- R8: Sawtooth at phase p equals p, so it rises from 0x00 to 0xFF and then wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Issue one sample and advance the phase on this edge |
| shape_sel | input | 2 | Waveform choice: 0 sine, 1 square, 2 triangle, 3 sawtooth |
| sample | output | RES_W | Registered offset-binary sample |
| sample_vld | output | 1 | High for one cycle after each issued sample |

## Verification
The bench holds a behavioural phase and computes every expected sample from trigonometry and plain arithmetic. It compares the outputs on every cycle across full periods of each shape, the phase wrap and the quadrant boundaries of the sine and the triangle. A design that mirrors the wrong quarter of the sine table, or that misses the 0x7F/0x80 split at the half period, shows up at phases 0x40, 0x80 and 0xC0. A triangle with an off-by-one fold point produces a doubled or skipped code at 0x3F/0x40 or at the 0xFF wrap.

Select changes are made while enable is low and in the middle of a period. A design that resets the phase when the select changes, or that lets the new select reach the held sample, diverges at once. Resets with different selects, including one in the middle of a run, catch a design that leaves the previous sample in place or clears the output to a fixed code instead of the phase-0 value.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

   typedef enum logic [1:0] {
      SHAPE_SINE   = 2'd0,
      SHAPE_SQUARE = 2'd1,
      SHAPE_TRI    = 2'd2,
      SHAPE_SAW    = 2'd3
   } shape_e;

   localparam int SEL_W = 2;

   // 2*pi scaled by 2^30, used to derive the per-step angle
   localparam longint TWO_PI_Q30 = 64'sd6746518852;
   localparam int     FRAC_BITS  = 30;
   localparam int     TAYLOR_N   = 6;

   // Rounded sine magnitude for quarter index k at a resolution of res_w bits.
   // The amplitude is 2^(res_w-1)-1 and the angle is 2*pi*k/2^res_w.
   function automatic int sine_quarter_mag(input int k, input int res_w);
      longint x;
      longint term;
      longint acc;
      longint amp;
      longint scaled;
      x    = longint'(k) * (TWO_PI_Q30 >>> res_w);
      term = x;
      acc  = x;
      for (int n = 1; n <= TAYLOR_N; n++) begin
         term = (term * x) >>> FRAC_BITS;
         term = (term * x) >>> FRAC_BITS;
         term = -term / longint'((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      amp    = (64'sd1 <<< (res_w - 1)) - 64'sd1;
      scaled = (acc * amp + (64'sd1 <<< (FRAC_BITS - 1))) >>> FRAC_BITS;
      if (scaled < 0)   scaled = 0;
      if (scaled > amp) scaled = amp;
      return int'(scaled);
   endfunction

endpackage

// File: rtl/wavegen_phase.sv
module wavegen_phase #(
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [RES_W-1:0] phase
);

   localparam logic [RES_W-1:0] STEP = RES_W'(1);

   initial begin
      if (RES_W < 4 || RES_W > 11)
         $error("wavegen_phase: RES_W must lie in 4..11");
   end

   always_ff @(posedge clk) begin
      if (rst)
         phase <= '0;
      else if (adv)
         phase <= phase + STEP;
   end

   // R2: each enabled edge moves the phase forward by exactly one, modulo the period
   a_r2_phase_advance: assert property (@(posedge clk) disable iff (rst)
      adv |=> phase == $past(phase) + STEP);

   // R3: no movement when not enabled
   a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
      !adv |=> phase == $past(phase));

   // R1: the first cycle after reset sees phase zero
   a_r1_phase_cleared: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> phase == '0);

endmodule

// File: rtl/wavegen_sine.sv
module wavegen_sine
   import wavegen_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic [RES_W-1:0] phase,
   output logic [RES_W-1:0] level
);

   localparam int QN    = 1 << (RES_W - 2);
   localparam int AMP_W = RES_W - 1;
   localparam int IDX_W = RES_W - 2;

   logic [AMP_W-1:0] quarter [0:QN];
   logic [1:0]       quadrant;
   logic [IDX_W-1:0] idx;
   logic [AMP_W-1:0] lut_addr;
   logic [AMP_W-1:0] mag;

   // Quarter-wave magnitude table, built at elaboration
   generate
      for (genvar g = 0; g <= QN; g++) begin : g_quarter
         localparam int MAG = sine_quarter_mag(g, RES_W);
         assign quarter[g] = AMP_W'(MAG);
      end
   endgenerate

   assign quadrant = phase[RES_W-1 -: 2];
   assign idx      = phase[IDX_W-1:0];

   // Odd quadrants read the table backwards, from the peak down
   always_comb begin
      if (quadrant[0])
         lut_addr = AMP_W'(QN) - AMP_W'(idx);
      else
         lut_addr = AMP_W'(idx);
   end

   assign mag = quarter[lut_addr];

   // First half sits above mid-scale; second half mirrors below it
   assign level = {~quadrant[1], quadrant[1] ? ~mag : mag};

   // R5: the upper half of the period never drops below mid-scale, the lower never reaches it
   always_comb begin
      a_r5_sine_half: assert (phase[RES_W-1] == ~level[RES_W-1]);
   end

endmodule

// File: rtl/wavegen_shapes.sv
module wavegen_shapes
   import wavegen_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic [RES_W-1:0] phase,
   input  shape_e           shape,
   output logic [RES_W-1:0] level
);

   localparam int IDX_W = RES_W - 2;

   logic [RES_W-1:0] sine_lvl;
   logic [RES_W-1:0] square_lvl;
   logic [RES_W-1:0] tri_lvl;
   logic [RES_W-1:0] saw_lvl;
   logic [1:0]       quadrant;
   logic [IDX_W-1:0] idx;
   logic [IDX_W:0]   idx_inc;

   wavegen_sine #(.RES_W(RES_W)) u_sine (
      .phase (phase),
      .level (sine_lvl)
   );

   assign quadrant = phase[RES_W-1 -: 2];
   assign idx      = phase[IDX_W-1:0];
   assign idx_inc  = {1'b0, idx} + (IDX_W+1)'(1);

   // Square: full scale for the first half, zero for the second
   assign square_lvl = {RES_W{~phase[RES_W-1]}};

   // Sawtooth: the phase itself
   assign saw_lvl = phase;

   // Triangle: slope of two codes per step, folding at the quarter points
   always_comb begin
      unique case (quadrant)
         2'd0:    tri_lvl = {1'b1, idx, 1'b0};
         2'd1:    tri_lvl = {1'b1, ~idx, 1'b0};
         2'd2:    tri_lvl = {1'b0, ~idx, 1'b0};
         default: tri_lvl = {idx_inc, 1'b0};
      endcase
   end

   always_comb begin
      unique case (shape)
         SHAPE_SINE:   level = sine_lvl;
         SHAPE_SQUARE: level = square_lvl;
         SHAPE_TRI:    level = tri_lvl;
         default:      level = saw_lvl;
      endcase
   end

endmodule

// File: rtl/wavegen_top.sv
module wavegen_top
   import wavegen_pkg::*;
#(
   parameter int RES_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_en,
   input  logic [1:0]       shape_sel,
   output logic [RES_W-1:0] sample,
   output logic             sample_vld
);

   logic [RES_W-1:0] phase;
   logic [RES_W-1:0] lookup_phase;
   logic [RES_W-1:0] shape_level;
   shape_e           shape;

   initial begin
      if (RES_W < 4 || RES_W > 11)
         $error("wavegen_top: RES_W must lie in 4..11");
   end

   assign shape = shape_e'(shape_sel);

   wavegen_phase #(.RES_W(RES_W)) u_phase (
      .clk   (clk),
      .rst   (rst),
      .adv   (step_en),
      .phase (phase)
   );

   // During reset the lookup is forced to phase zero so the output is primed
   assign lookup_phase = rst ? '0 : phase;

   wavegen_shapes #(.RES_W(RES_W)) u_shapes (
      .phase (lookup_phase),
      .shape (shape),
      .level (shape_level)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sample     <= shape_level;
         sample_vld <= 1'b0;
      end else if (step_en) begin
         sample     <= shape_level;
         sample_vld <= 1'b1;
      end else begin
         sample_vld <= 1'b0;
      end
   end

   // R2: an issued sample is flagged in the following cycle
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
      step_en |=> sample_vld);

   // R3: with enable low the output is frozen and not flagged
   a_r3_output_hold: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(sample) && !sample_vld);

   // R8: sawtooth output reproduces the phase it was taken from
   a_r8_saw_tracks_phase: assert property (@(posedge clk) disable iff (rst)
      step_en && shape_sel == 2'd3 |=> sample == $past(phase));

   // R6: square output is one of the two rails, chosen by the phase half
   a_r6_square_rails: assert property (@(posedge clk) disable iff (rst)
      step_en && shape_sel == 2'd1 |=>
         sample == ($past(phase[RES_W-1]) ? '0 : '1));

   // R7: triangle codes are always even
   a_r7_tri_even: assert property (@(posedge clk) disable iff (rst)
      step_en && shape_sel == 2'd2 |=> !sample[0]);

endmodule

// File: tb/wavegen_top_tb.sv
`timescale 1ns/1ps
module wavegen_top_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       step_en = 1'b0;
   logic [1:0] shape_sel = 2'd0;
   logic [7:0] sample;
   logic       sample_vld;

   int    n_checks = 0;
   int    n_errors = 0;
   int    m_phase = 0;
   int    m_sample = 0;
   int    m_vld = 0;
   string ctx = "";
   bit    done = 1'b0;

   always #4 clk = ~clk;

   wavegen_top #(.RES_W(8)) u_dut (
      .clk        (clk),
      .rst        (rst),
      .step_en    (step_en),
      .shape_sel  (shape_sel),
      .sample     (sample),
      .sample_vld (sample_vld)
   );

   function automatic int round_mag(input int p);
      real a;
      a = 127.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 256.0);
      return $rtoi(a + 0.5);
   endfunction

   function automatic int ref_level(input int s, input int p);
      case (s)
         0: return (p < 128) ? 128 + round_mag(p) : 127 - round_mag(p - 128);
         1: return (p < 128) ? 255 : 0;
         2: begin
            if (p < 64)       return 128 + 2 * p;
            else if (p < 128) return 254 - 2 * (p - 64);
            else if (p < 192) return 126 - 2 * (p - 128);
            else              return 2 + 2 * (p - 192);
         end
         default: return p;
      endcase
   endfunction

   function automatic string shape_tag(input int s);
      case (s)
         0: return "R5 sine";
         1: return "R6 square";
         2: return "R7 triangle";
         default: return "R8 sawtooth";
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // One clock: apply inputs, update the model at the edge, compare after it
   task automatic tick(input bit r, input bit en, input int s);
      string tag;
      rst       = r;
      step_en   = en;
      shape_sel = 2'(s);
      @(posedge clk);
      if (r) begin
         tag      = "R1 reset";
         m_phase  = 0;
         m_sample = ref_level(s, 0);
         m_vld    = 0;
      end else if (en) begin
         tag      = (m_phase == 255) ? {"R2 wrap ", shape_tag(s)} : shape_tag(s);
         m_sample = ref_level(s, m_phase);
         m_phase  = (m_phase + 1) % 256;
         m_vld    = 1;
      end else begin
         tag   = "R3 hold";
         m_vld = 0;
      end
      @(negedge clk);
      check({ctx, tag, " sample"}, int'(sample), m_sample);
      check({ctx, tag, " valid"}, int'(sample_vld), m_vld);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      @(negedge clk);
      // R1: reset primes the phase-0 value of each shape
      tick(1, 0, 1);
      tick(1, 1, 2);
      tick(1, 0, 3);
      tick(1, 0, 0);

      // full periods of every shape, plus a wrap
      for (int s = 0; s < 4; s++)
         for (int i = 0; i < 256; i++) tick(0, 1, s);
      for (int i = 0; i < 10; i++) tick(0, 1, 3);

      // R3: enable low, select changes while frozen
      for (int i = 0; i < 8; i++) tick(0, 0, i % 4);
      tick(0, 1, 2);

      // R4: select changes mid-period keep the phase running
      ctx = "R4 ";
      for (int i = 0; i < 300; i++) tick(0, 1, (i / 7) % 4);
      ctx = "";

      // R1: mid-run reset with sine selected
      for (int i = 0; i < 5; i++) tick(0, 1, 1);
      tick(1, 1, 0);
      for (int i = 0; i < 70; i++) tick(0, 1, 0);

      // mixed enable and select pattern
      lfsr = 16'hACE1;
      for (int i = 0; i < 2000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tick(lfsr[7:0] == 8'h00, lfsr[3] | lfsr[9], int'(lfsr[5:4]));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule